// File: doc/BRIEF.md
# Interrupt Bidding Arbiter for a Four-Channel Serial Controller

This block decides which of many interrupt sources in a four-channel serial controller gets the host's attention. Every channel offers six sources: its receiver, its transmitter, and four event sources (line-break change, I/O-pin change, flow-control character, address match). Each active source builds a 10-bit bid. The upper field is a FIFO count or a value that software programs. The middle bits are a code for the source type. The low three bits are the channel number. A comparator tree finds the largest bid, so the winner comes from a plain numeric comparison and not from a fixed priority list.

The winning bid is compared with a software threshold. The interrupt line goes low only while the winner is strictly above that threshold. The winner is then latched into a current-interrupt register, which a host handler reads to see which source to service and on which channel. A watchdog flag from any receiver narrows the contest to receivers alone and drops the threshold to zero, so stale receive data is drained first.

The FIFO levels, event flags, enables, programmed bid values, watchdog flags and threshold all arrive as inputs. The serial datapaths and the register decode are outside this block.

Top module: `irq_bid_arbiter`

## Requirements
- R1: An enabled receiver with a fill level above zero bids {min(fill-1,15) in bits 9:6, type 001 (no error) or 101 (error) in bits 5:3, channel in bits 2:0}. A receiver with fill zero does not bid.
- R2: An enabled transmitter with free room above zero bids {min(room-1,15) shifted right by one in bits 9:6, type 011 in bits 5:3, channel}. Its count therefore weighs half as much as a receiver count.
- R3: An event source with its flag set and a nonzero 4-bit programmed value bids {value in bits 9:6, type in bits 5:3, channel}. The types are: break 010, pin change 110, flow-control 111, address match 100. A programmed value of zero keeps the source out of the contest.
- R4: The registered winner is the numerically largest bid. Bids equal above the channel field resolve to the higher channel number. The channel and type outputs equal bits 2:0 and 6:3 of the winner.
- R5: One clock after the inputs change, irq_n is low and win_valid is high if and only if the largest bid is strictly greater than {threshold[6:0], 000}. Otherwise win_bid shows that threshold bid.
- R6: While any watchdog flag is set, only enabled receivers bid and the threshold is taken as zero.
- R7: A receiver or transmitter with its enable low never bids, whatever its FIFO level.
- R8: The current-interrupt register loads the winner on the edge where irq_n falls, or on any edge with upd_cir high, and holds its value at all other times. An update with no bid above the threshold loads the threshold bid.
- R9: Reset sets irq_n high and clears win_valid, win_bid and the current-interrupt register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_fill | input | 20 | Receive FIFO fill level, 5 bits per channel |
| rx_err | input | 1x4 | Receive data at the FIFO head carries an error, one bit per channel |
| rx_en | input | 4 | Receiver interrupt enable, one bit per channel |
| tx_room | input | 20 | Transmit FIFO free slots, 5 bits per channel |
| tx_en | input | 4 | Transmitter interrupt enable, one bit per channel |
| brk_evt | input | 4 | Break-change event flag, one bit per channel |
| pin_evt | input | 4 | I/O pin change event flag, one bit per channel |
| flow_evt | input | 4 | Flow-control character event flag, one bit per channel |
| addr_evt | input | 4 | Address match event flag, one bit per channel |
| brk_val | input | 16 | Programmed bid value for the break source, 4 bits per channel |
| pin_val | input | 16 | Programmed bid value for the pin-change source, 4 bits per channel |
| flow_val | input | 16 | Programmed bid value for the flow-control source, 4 bits per channel |
| addr_val | input | 16 | Programmed bid value for the address-match source, 4 bits per channel |
| wd_bark | input | 4 | Receiver watchdog timeout flag, one bit per channel |
| thr_lvl | input | 7 | Threshold value, upper field of the threshold bid |
| upd_cir | input | 1 | Force a load of the current-interrupt register |
| irq_n | output | 1 | Interrupt request, active low |
| win_valid | output | 1 | Registered winner is above the threshold |
| win_bid | output | 10 | Registered winning bid (the threshold bid when none exceeds it) |
| win_ch | output | 3 | Channel field of the winner |
| win_type | output | 4 | Bits 6:3 of the winner |
| cir_bid | output | 10 | Current-interrupt register |

## Verification
The assertions assume that the inputs stay fixed over each clock and change only between edges. They also assume that rst_n is released away from an edge, so every `$past` term sees a settled value. The stimulus meets this by changing every input on the falling edge only, and by holding each setting for at least one full cycle before the outputs are sampled. The checks on threshold compliance and on the watchdog restriction rely on this one-cycle relation between the inputs and the registered winner. The checks on the current-interrupt register assume that upd_cir is a level sampled at the edge. The bench pulses it for exactly one cycle.

// File: rtl/irq_bid_pkg.sv
package irq_bid_pkg;
   // Source slot order within one channel
   typedef enum logic [2:0] {
      SRC_RX   = 3'd0,
      SRC_TX   = 3'd1,
      SRC_BRK  = 3'd2,
      SRC_PIN  = 3'd3,
      SRC_FLOW = 3'd4,
      SRC_ADDR = 3'd5
   } src_slot_e;

   localparam int unsigned SRC_PER_CH = 6;
   localparam int unsigned TYPE_W     = 3;

   // Type codes placed directly above the channel field
   localparam logic [TYPE_W-1:0] TC_RX_OK  = 3'b001;
   localparam logic [TYPE_W-1:0] TC_RX_ERR = 3'b101;
   localparam logic [TYPE_W-1:0] TC_TX     = 3'b011;
   localparam logic [TYPE_W-1:0] TC_BRK    = 3'b010;
   localparam logic [TYPE_W-1:0] TC_PIN    = 3'b110;
   localparam logic [TYPE_W-1:0] TC_FLOW   = 3'b111;
   localparam logic [TYPE_W-1:0] TC_ADDR   = 3'b100;
endpackage

// File: rtl/irq_bid_former.sv
module irq_bid_former
   import irq_bid_pkg::*;
#(
   parameter int unsigned CH_W    = 3,
   parameter int unsigned FILL_W  = 5,
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned CH_ID   = 0,
   localparam int unsigned BID_W  = CNT_W + TYPE_W + CH_W
) (
   input  logic [FILL_W-1:0]            rx_fill,
   input  logic                         rx_err,
   input  logic                         rx_en,
   input  logic [FILL_W-1:0]            tx_room,
   input  logic                         tx_en,
   input  logic                         brk_evt,
   input  logic                         pin_evt,
   input  logic                         flow_evt,
   input  logic                         addr_evt,
   input  logic [CNT_W-1:0]             brk_val,
   input  logic [CNT_W-1:0]             pin_val,
   input  logic [CNT_W-1:0]             flow_val,
   input  logic [CNT_W-1:0]             addr_val,
   input  logic                         rx_only,
   output logic [SRC_PER_CH-1:0]        bid_v,
   output logic [SRC_PER_CH*BID_W-1:0]  bid
);
   localparam logic [CH_W-1:0]  CH_FIELD = CH_W'(CH_ID);
   localparam int unsigned      CNT_MAX  = (1 << CNT_W) - 1;

   // Saturating level-minus-one into the count field
   function automatic logic [CNT_W-1:0] lvl_to_cnt(input logic [FILL_W-1:0] lvl);
      logic [FILL_W:0] dec;
      dec = {1'b0, lvl} - 1'b1;
      if (dec > (FILL_W+1)'(CNT_MAX)) return CNT_W'(CNT_MAX);
      else                           return dec[CNT_W-1:0];
   endfunction

   logic [CNT_W-1:0] rx_cnt, tx_cnt;
   logic [TYPE_W-1:0] rx_tc;

   always_comb begin
      rx_cnt = lvl_to_cnt(rx_fill);
      tx_cnt = lvl_to_cnt(tx_room) >> 1;
      rx_tc  = rx_err ? TC_RX_ERR : TC_RX_OK;
   end

   always_comb begin
      bid_v[SRC_RX]   = rx_en && (rx_fill != '0);
      bid_v[SRC_TX]   = !rx_only && tx_en && (tx_room != '0);
      bid_v[SRC_BRK]  = !rx_only && brk_evt  && (brk_val  != '0);
      bid_v[SRC_PIN]  = !rx_only && pin_evt  && (pin_val  != '0);
      bid_v[SRC_FLOW] = !rx_only && flow_evt && (flow_val != '0);
      bid_v[SRC_ADDR] = !rx_only && addr_evt && (addr_val != '0);
   end

   always_comb begin
      bid[SRC_RX*BID_W   +: BID_W] = {rx_cnt,   rx_tc,   CH_FIELD};
      bid[SRC_TX*BID_W   +: BID_W] = {tx_cnt,   TC_TX,   CH_FIELD};
      bid[SRC_BRK*BID_W  +: BID_W] = {brk_val,  TC_BRK,  CH_FIELD};
      bid[SRC_PIN*BID_W  +: BID_W] = {pin_val,  TC_PIN,  CH_FIELD};
      bid[SRC_FLOW*BID_W +: BID_W] = {flow_val, TC_FLOW, CH_FIELD};
      bid[SRC_ADDR*BID_W +: BID_W] = {addr_val, TC_ADDR, CH_FIELD};
   end
endmodule

// File: rtl/irq_bid_max_tree.sv
module irq_bid_max_tree #(
   parameter int unsigned N_IN  = 24,
   parameter int unsigned BID_W = 10,
   localparam int unsigned LVLS = (N_IN > 1) ? $clog2(N_IN) : 1,
   localparam int unsigned LEAF = 1 << LVLS,
   localparam int unsigned NODE = 2*LEAF - 1
) (
   input  logic [N_IN-1:0]        in_v,
   input  logic [N_IN*BID_W-1:0]  in_bid,
   output logic                   max_v,
   output logic [BID_W-1:0]       max_bid
);
   logic             nv [NODE];
   logic [BID_W-1:0] nb [NODE];

   // Leaves, padded with idle slots up to a power of two
   for (genvar li = 0; li < LEAF; li++) begin : g_leaf
      if (li < N_IN) begin : g_real
         assign nv[LEAF-1+li] = in_v[li];
         assign nb[LEAF-1+li] = in_bid[li*BID_W +: BID_W];
      end else begin : g_pad
         assign nv[LEAF-1+li] = 1'b0;
         assign nb[LEAF-1+li] = '0;
      end
   end

   // Inner nodes: keep the larger of two valid children
   for (genvar ni = 0; ni < LEAF-1; ni++) begin : g_node
      logic pick_r;
      assign pick_r = nv[2*ni+2] && (!nv[2*ni+1] || (nb[2*ni+2] > nb[2*ni+1]));
      assign nv[ni] = nv[2*ni+1] || nv[2*ni+2];
      assign nb[ni] = pick_r ? nb[2*ni+2] : nb[2*ni+1];
   end

   assign max_v   = nv[0];
   assign max_bid = nb[0];
endmodule

// File: rtl/irq_bid_resolver.sv
module irq_bid_resolver #(
   parameter int unsigned BID_W = 10,
   parameter int unsigned CH_W  = 3,
   localparam int unsigned THR_W = BID_W - CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              max_v,
   input  logic [BID_W-1:0]  max_bid,
   input  logic [THR_W-1:0]  thr_lvl,
   input  logic              zero_thr,
   input  logic              upd_cir,
   output logic              irq_n,
   output logic              win_valid,
   output logic [BID_W-1:0]  win_bid,
   output logic [BID_W-1:0]  cir_bid
);
   logic [BID_W-1:0] thr_bid;
   logic             above;
   logic [BID_W-1:0] shown;
   logic             load_cir;

   always_comb begin
      thr_bid  = zero_thr ? '0 : {thr_lvl, {CH_W{1'b0}}};
      above    = max_v && (max_bid > thr_bid);
      shown    = above ? max_bid : thr_bid;
      // irq_n still high while a bid now exceeds the threshold: falling edge
      load_cir = (above && irq_n) || upd_cir;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n     <= 1'b1;
         win_valid <= 1'b0;
         win_bid   <= '0;
         cir_bid   <= '0;
      end else begin
         irq_n     <= !above;
         win_valid <= above;
         win_bid   <= shown;
         if (load_cir) cir_bid <= shown;
      end
   end
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
   import irq_bid_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 3,
   parameter int unsigned FILL_W = 5,
   parameter int unsigned CNT_W  = 4,
   localparam int unsigned BID_W = CNT_W + TYPE_W + CH_W,
   localparam int unsigned THR_W = BID_W - CH_W,
   localparam int unsigned N_SRC = NUM_CH * SRC_PER_CH
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*FILL_W-1:0] rx_fill,
   input  logic [NUM_CH-1:0]        rx_err,
   input  logic [NUM_CH-1:0]        rx_en,
   input  logic [NUM_CH*FILL_W-1:0] tx_room,
   input  logic [NUM_CH-1:0]        tx_en,
   input  logic [NUM_CH-1:0]        brk_evt,
   input  logic [NUM_CH-1:0]        pin_evt,
   input  logic [NUM_CH-1:0]        flow_evt,
   input  logic [NUM_CH-1:0]        addr_evt,
   input  logic [NUM_CH*CNT_W-1:0]  brk_val,
   input  logic [NUM_CH*CNT_W-1:0]  pin_val,
   input  logic [NUM_CH*CNT_W-1:0]  flow_val,
   input  logic [NUM_CH*CNT_W-1:0]  addr_val,
   input  logic [NUM_CH-1:0]        wd_bark,
   input  logic [THR_W-1:0]         thr_lvl,
   input  logic                     upd_cir,
   output logic                     irq_n,
   output logic                     win_valid,
   output logic [BID_W-1:0]         win_bid,
   output logic [CH_W-1:0]          win_ch,
   output logic [TYPE_W:0]          win_type,
   output logic [BID_W-1:0]         cir_bid
);
   // Elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_ch
      $error("irq_bid_arbiter: NUM_CH must fit in the channel field");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("irq_bid_arbiter: CNT_W must be at least 2");
   end
   if (FILL_W < 1) begin : g_bad_fill
      $error("irq_bid_arbiter: FILL_W must be at least 1");
   end

   logic                     rx_only;
   logic [N_SRC-1:0]         all_v;
   logic [N_SRC*BID_W-1:0]   all_bid;
   logic                     max_v;
   logic [BID_W-1:0]         max_bid;

   assign rx_only = |wd_bark;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      irq_bid_former #(
         .CH_W   (CH_W),
         .FILL_W (FILL_W),
         .CNT_W  (CNT_W),
         .CH_ID  (ch)
      ) u_former (
         .rx_fill  (rx_fill[ch*FILL_W +: FILL_W]),
         .rx_err   (rx_err[ch]),
         .rx_en    (rx_en[ch]),
         .tx_room  (tx_room[ch*FILL_W +: FILL_W]),
         .tx_en    (tx_en[ch]),
         .brk_evt  (brk_evt[ch]),
         .pin_evt  (pin_evt[ch]),
         .flow_evt (flow_evt[ch]),
         .addr_evt (addr_evt[ch]),
         .brk_val  (brk_val[ch*CNT_W +: CNT_W]),
         .pin_val  (pin_val[ch*CNT_W +: CNT_W]),
         .flow_val (flow_val[ch*CNT_W +: CNT_W]),
         .addr_val (addr_val[ch*CNT_W +: CNT_W]),
         .rx_only  (rx_only),
         .bid_v    (all_v[ch*SRC_PER_CH +: SRC_PER_CH]),
         .bid      (all_bid[ch*SRC_PER_CH*BID_W +: SRC_PER_CH*BID_W])
      );
   end

   irq_bid_max_tree #(
      .N_IN  (N_SRC),
      .BID_W (BID_W)
   ) u_tree (
      .in_v    (all_v),
      .in_bid  (all_bid),
      .max_v   (max_v),
      .max_bid (max_bid)
   );

   irq_bid_resolver #(
      .BID_W (BID_W),
      .CH_W  (CH_W)
   ) u_resolve (
      .clk       (clk),
      .rst_n     (rst_n),
      .max_v     (max_v),
      .max_bid   (max_bid),
      .thr_lvl   (thr_lvl),
      .zero_thr  (rx_only),
      .upd_cir   (upd_cir),
      .irq_n     (irq_n),
      .win_valid (win_valid),
      .win_bid   (win_bid),
      .cir_bid   (cir_bid)
   );

   assign win_ch   = win_bid[CH_W-1:0];
   assign win_type = win_bid[CH_W+TYPE_W:CH_W];
endmodule

// File: rtl/irq_bid_arbiter_chk.sv
module irq_bid_arbiter_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 3,
   parameter int unsigned BID_W  = 10,
   localparam int unsigned THR_W = BID_W - CH_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] wd_bark,
   input logic [THR_W-1:0]  thr_lvl,
   input logic              upd_cir,
   input logic              irq_n,
   input logic              win_valid,
   input logic [BID_W-1:0]  win_bid,
   input logic [CH_W-1:0]   win_ch,
   input logic [BID_W-1:0]  cir_bid
);
   p_winner_ch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_ch < CH_W'(NUM_CH)));

   p_above_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !$past(|wd_bark)) |-> (win_bid[BID_W-1:CH_W] >= $past(thr_lvl)));

   p_wd_rx_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && $past(|wd_bark)) |-> (win_bid[CH_W+1:CH_W] == 2'b01));

   p_cir_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> (cir_bid == win_bid));

   p_cir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(upd_cir) && !$fell(irq_n)) |-> $stable(cir_bid));

   p_reset_r9: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_n && !win_valid && cir_bid == '0));
endmodule

bind irq_bid_arbiter irq_bid_arbiter_chk #(
   .NUM_CH (NUM_CH),
   .CH_W   (CH_W),
   .BID_W  (BID_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wd_bark   (wd_bark),
   .thr_lvl   (thr_lvl),
   .upd_cir   (upd_cir),
   .irq_n     (irq_n),
   .win_valid (win_valid),
   .win_bid   (win_bid),
   .win_ch    (win_ch),
   .cir_bid   (cir_bid)
);

// File: tb/irq_bid_arbiter_tb.sv
`timescale 1ns/1ps
module irq_bid_arbiter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] rx_fill, tx_room;
   logic [3:0]  rx_err, rx_en, tx_en, brk_evt, pin_evt, flow_evt, addr_evt, wd_bark;
   logic [15:0] brk_val, pin_val, flow_val, addr_val;
   logic [6:0]  thr_lvl;
   logic        upd_cir;
   logic        irq_n, win_valid;
   logic [9:0]  win_bid, cir_bid;
   logic [2:0]  win_ch;
   logic [3:0]  win_type;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_bid_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_err(rx_err), .rx_en(rx_en),
      .tx_room(tx_room), .tx_en(tx_en), .brk_evt(brk_evt), .pin_evt(pin_evt),
      .flow_evt(flow_evt), .addr_evt(addr_evt), .brk_val(brk_val), .pin_val(pin_val),
      .flow_val(flow_val), .addr_val(addr_val), .wd_bark(wd_bark), .thr_lvl(thr_lvl),
      .upd_cir(upd_cir), .irq_n(irq_n), .win_valid(win_valid), .win_bid(win_bid),
      .win_ch(win_ch), .win_type(win_type), .cir_bid(cir_bid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_all();
      rx_fill = '0; tx_room = '0; rx_err = '0; rx_en = '0; tx_en = '0;
      brk_evt = '0; pin_evt = '0; flow_evt = '0; addr_evt = '0; wd_bark = '0;
      brk_val = '0; pin_val = '0; flow_val = '0; addr_val = '0;
      thr_lvl = '0; upd_cir = 1'b0;
   endtask

   task automatic set_rx(input int ch, input int lvl, input bit err);
      rx_fill[ch*5 +: 5] = 5'(lvl); rx_err[ch] = err; rx_en[ch] = 1'b1;
   endtask

   task automatic set_tx(input int ch, input int room);
      tx_room[ch*5 +: 5] = 5'(room); tx_en[ch] = 1'b1;
   endtask

   task automatic t_reset();
      chk("R9 irq_n", irq_n, 1);
      chk("R9 win_valid", win_valid, 0);
      chk("R9 win_bid", win_bid, 0);
      chk("R9 cir_bid", cir_bid, 0);
   endtask

   task automatic t_receiver();
      clear_all(); step();
      set_rx(1, 3, 0); step();
      chk("R1 rx bid", win_bid, 137);
      chk("R4 win_ch", win_ch, 1);
      chk("R4 win_type", win_type, 1);
      chk("R5 irq_n", irq_n, 0);
      chk("R8 cir on fall", cir_bid, 137);
      set_rx(0, 3, 1); step();
      chk("R1 rx error type wins", win_bid, 168);
      chk("R4 win_type err", win_type, 5);
   endtask

   task automatic t_transmitter();
      clear_all(); step();
      set_tx(0, 3); set_rx(1, 3, 0); step();
      chk("R2 rx outranks tx", win_bid, 137);
      rx_en = '0; step();
      chk("R2 tx bid room3", win_bid, 88);
      chk("R4 win_type tx", win_type, 11);
      set_tx(0, 5); step();
      chk("R2 tx bid room5", win_bid, 152);
      set_tx(2, 31); tx_en[0] = 1'b0; step();
      chk("R2 tx saturate", win_bid, 474);
   endtask

   task automatic t_programmed();
      clear_all(); step();
      set_rx(1, 3, 0); brk_evt[2] = 1'b1; brk_val[2*4 +: 4] = 4'd15; step();
      chk("R3 break bid", win_bid, 978);
      clear_all(); pin_evt[3] = 1'b1; step();
      chk("R3 zero value excluded irq_n", irq_n, 1);
      chk("R3 zero value excluded bid", win_bid, 0);
      addr_evt[3] = 1'b1; addr_val[3*4 +: 4] = 4'd1; step();
      chk("R3 addr bid", win_bid, 99);
      pin_evt[1] = 1'b1; pin_val[1*4 +: 4] = 4'd2; step();
      chk("R3 pin bid", win_bid, 177);
      flow_evt[0] = 1'b1; flow_val[0 +: 4] = 4'd2; step();
      chk("R3 flow bid", win_bid, 184);
   endtask

   task automatic t_tie();
      clear_all(); step();
      set_rx(0, 3, 0); set_rx(3, 3, 0); step();
      chk("R4 tie high channel bid", win_bid, 139);
      chk("R4 tie high channel ch", win_ch, 3);
      clear_all(); set_rx(1, 20, 0); brk_evt[0] = 1'b1; brk_val[0 +: 4] = 4'd15; step();
      chk("R4 break over full rx", win_bid, 960 + 16);
      brk_evt = '0; step();
      chk("R1 rx saturate", win_bid, 969);
   endtask

   task automatic t_threshold();
      clear_all(); step();
      thr_lvl = 7'd1; set_rx(0, 1, 0); step();
      chk("R5 equal not above irq_n", irq_n, 1);
      chk("R5 equal not above valid", win_valid, 0);
      chk("R5 shows threshold bid", win_bid, 8);
      set_rx(1, 1, 0); step();
      chk("R5 above irq_n", irq_n, 0);
      chk("R5 above bid", win_bid, 9);
   endtask

   task automatic t_enables();
      clear_all(); step();
      rx_fill[1*5 +: 5] = 5'd10; tx_room[2*5 +: 5] = 5'd8; step();
      chk("R7 disabled irq_n", irq_n, 1);
      chk("R7 disabled bid", win_bid, 0);
   endtask

   task automatic t_watchdog();
      clear_all(); step();
      thr_lvl = 7'd127; brk_evt[2] = 1'b1; brk_val[2*4 +: 4] = 4'd15;
      set_rx(0, 2, 0); set_tx(1, 16); wd_bark[3] = 1'b1; step();
      chk("R6 wd rx wins", win_bid, 72);
      chk("R6 wd irq_n", irq_n, 0);
      chk("R6 wd win_ch", win_ch, 0);
      rx_en = '0; step();
      chk("R6 wd no rx irq_n", irq_n, 1);
      chk("R6 wd zero threshold bid", win_bid, 0);
      wd_bark = '0; step();
      chk("R5 high threshold bid", win_bid, 1016);
      chk("R5 high threshold irq_n", irq_n, 1);
   endtask

   task automatic t_cir();
      clear_all(); step();
      set_rx(0, 2, 0); step();
      chk("R8 capture", cir_bid, 72);
      set_rx(1, 5, 0); step();
      chk("R8 winner moves", win_bid, 265);
      chk("R8 hold while low", cir_bid, 72);
      upd_cir = 1'b1; step(); upd_cir = 1'b0;
      chk("R8 update load", cir_bid, 265);
      clear_all(); step();
      chk("R8 hold after withdraw", cir_bid, 265);
      chk("R5 withdraw irq_n", irq_n, 1);
      upd_cir = 1'b1; step(); upd_cir = 1'b0;
      chk("R8 update idle loads threshold", cir_bid, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      clear_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_receiver();
      t_transmitter();
      t_programmed();
      t_tie();
      t_threshold();
      t_enables();
      t_watchdog();
      t_cir();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule